// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block compares a reference square wave against a feedback square wave, both sampled on a fast system clock. It is meant for a digital or mixed-signal loop. Each input passes through a multi-flop synchroniser, and a rising-edge detector turns each input into a one-cycle pulse. A three-state register (released, pumping up, pumping down) tracks which input's rising edge came first. The error output is a data bit with an output-enable bit, so a pad or an analog charge stage can drive high, drive low, or float.

When the reference edge leads, the output drives high until the feedback edge arrives. When the feedback edge leads, the output drives low until the reference edge arrives. Otherwise the output is released, so an external filter holds its level. A lock flag is high exactly while the output is released. Only rising edges matter, so duty cycle has no effect. Because the state follows edges rather than levels, a feedback running at a multiple of the reference keeps producing drive pulses, and the loop cannot rest on a harmonic.

Top module: `pfd_tristate`

## Requirements
- R1: A synchronous active-high reset sets the block to released: err_oe = 0, err_data = 0 and lock_ok = 1 in the cycle after the reset edge. This takes effect even in the middle of a drive interval.
- R2: If a reference rising edge comes D clock cycles before a feedback rising edge, the output is driven high (err_oe = 1, err_data = 1) for exactly D cycles and is then released.
- R3: If a feedback rising edge comes D clock cycles before a reference rising edge, the output is driven low (err_oe = 1, err_data = 0) for exactly D cycles and is then released.
- R4: Rising edges on both inputs that are seen in the same clock cycle cause no drive. From released the block stays released, and from a drive state it returns to released.
- R5: Only rising edges count. Changing the high time of either input, with its rising edges kept the same, leaves the output unchanged.
- R6: lock_ok is 1 exactly when err_oe is 0, and err_data is 0 whenever err_oe is 0.
- R7: With the reference input idle, the first feedback rising edge drives the output low, and it stays driven low.
- R8: A further rising edge on the leading input during a drive interval neither extends nor re-counts it. One rising edge on the other input releases the output.
- R9: With the feedback at twice the reference frequency and rising edges coincident once per reference period, the output is driven low for one feedback period in every reference period. The block never stays released.
- R10: A rising edge on an input that is first sampled high at clock edge k changes the output at clock edge k + SYNC_STAGES. The default SYNC_STAGES is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference square wave |
| fb_in | input | 1 | Asynchronous feedback square wave |
| err_data | output | 1 | Error level while driven: 1 pumps up, 0 pumps down |
| err_oe | output | 1 | Error output enable; 0 means the output is released |
| lock_ok | output | 1 | High while no error interval is in progress |

## Verification
A level applied before clock edge k reaches the output just after edge k + 2: two synchroniser flops, then the state register. As a result, a drive interval starting from an edge offset of D cycles spans exactly D samples. The bench changes inputs and reads outputs on falling clock edges, and totals the high-drive and low-drive samples over a window that runs several cycles past the last stimulus. Those totals are then compared with sums of edge offsets computed by hand. The directed tests check the exact sample at which the output must still be released and the next sample, at which it must be driving, to pin down the two-cycle latency.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_REL = 2'd0,
        ST_UP  = 2'd1,
        ST_DN  = 2'd2
    } pfd_state_e;

    typedef struct packed {
        pfd_state_e state;
        logic       data;
        logic       oe;
        logic       lock;
    } pfd_regs_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    // Newest synchronised sample high, one-cycle-older sample low.
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic err_data,
    output logic err_oe,
    output logic lock_ok
);
    pfd_regs_t regs_d, regs_q;
    pfd_state_e nxt;

    always_comb begin
        nxt = regs_q.state;
        unique case (regs_q.state)
            ST_REL: begin
                if (ref_rise && !fb_rise)      nxt = ST_UP;
                else if (fb_rise && !ref_rise) nxt = ST_DN;
            end
            ST_UP:   if (fb_rise)  nxt = ST_REL;
            ST_DN:   if (ref_rise) nxt = ST_REL;
            default: nxt = ST_REL;
        endcase
        regs_d.state = nxt;
        regs_d.data  = (nxt == ST_UP);
        regs_d.oe    = (nxt != ST_REL);
        regs_d.lock  = (nxt == ST_REL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.state <= ST_REL;
            regs_q.data  <= 1'b0;
            regs_q.oe    <= 1'b0;
            regs_q.lock  <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign err_data = regs_q.data;
    assign err_oe   = regs_q.oe;
    assign lock_ok  = regs_q.lock;

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic err_data,
    output logic err_oe,
    output logic lock_ok
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] rise_vec;
    logic              ref_rise;
    logic              fb_rise;

    assign raw_in = {fb_in, ref_in};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .rise (rise_vec[g])
        );
    end

    assign ref_rise = rise_vec[0];
    assign fb_rise  = rise_vec[1];

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (ref_rise),
        .fb_rise  (fb_rise),
        .err_data (err_data),
        .err_oe   (err_oe),
        .lock_ok  (lock_ok)
    );

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
    input logic clk,
    input logic rst,
    input logic ref_rise,
    input logic fb_rise,
    input logic err_data,
    input logic err_oe,
    input logic lock_ok
);
    // R1: reset leaves the block released with lock high
    a_r1_reset_released: assert property (@(posedge clk)
        rst |=> (lock_ok && !err_oe && !err_data));

    // R6: lock flag mirrors a released output; data is low when released
    always @(posedge clk) begin
        if (!rst) begin
            a_r6_lock_vs_oe: assert (lock_ok == !err_oe);
            a_r6_data_released: assert (err_oe || !err_data);
        end
    end

    // R2: high drive persists until a feedback edge
    a_r2_up_holds: assert property (@(posedge clk) disable iff (rst)
        (err_oe && err_data && !fb_rise && !rst) |=> (err_oe && err_data));

    // R3: low drive persists until a reference edge
    a_r3_dn_holds: assert property (@(posedge clk) disable iff (rst)
        (err_oe && !err_data && !ref_rise && !rst) |=> (err_oe && !err_data));

    // R4: coincident edges from released produce no drive
    a_r4_both_no_drive: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise && !err_oe) |=> !err_oe);

    // R8: one opposite edge ends a high drive
    a_r8_up_released: assert property (@(posedge clk) disable iff (rst)
        (err_oe && err_data && fb_rise) |=> !err_oe);

    // R8: one opposite edge ends a low drive
    a_r8_dn_released: assert property (@(posedge clk) disable iff (rst)
        (err_oe && !err_data && ref_rise) |=> !err_oe);

endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .err_data (err_data),
    .err_oe   (err_oe),
    .lock_ok  (lock_ok)
);

// File: tb/pfd_tristate_bench.sv
`timescale 1ns/1ps
module pfd_tristate_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic err_data, err_oe, lock_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfd_tristate u_pfd_tristate (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .err_data (err_data),
        .err_oe   (err_oe),
        .lock_ok  (lock_ok)
    );

    typedef struct packed {
        int rp; int rh; int ro;   // reference period, high time, first rise
        int fp; int fh; int fo;   // feedback period, high time, first rise
        int up; int dn;           // expected high-drive / low-drive samples
        int req;                  // requirement number
    } vec_t;

    localparam int NVEC = 7;
    localparam int STIM = 200;
    localparam int TAIL = 8;

    localparam vec_t VECS [NVEC] = '{
        '{20, 10, 2, 20, 10, 7,  50,   0, 2},  // R2 ref leads by 5
        '{20, 10, 9, 20, 10, 2,   0,  70, 3},  // R3 fb leads by 7
        '{20, 10, 2, 20, 10, 2,   0,   0, 4},  // R4 aligned
        '{ 0,  0, 0, 20, 10, 2,   0, 205, 7},  // R7 no reference
        '{40, 20, 2, 20, 10, 2,   0, 105, 9},  // R9 fb at twice ref
        '{20, 10, 2, 40, 20, 2, 105,   0, 9},  // R9 ref at twice fb
        '{20,  3, 2, 20, 17, 6,  40,   0, 5}   // R5 skewed duty, lead 4
    };

    function automatic logic wave(int t, int p, int h, int off);
        if (p == 0 || t > STIM || t < off) return 1'b0;
        return (((t - off) % p) < h);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    int up_cnt, dn_cnt, bad_cnt;

    task automatic sample_out();
        if (err_oe && err_data)  up_cnt++;
        if (err_oe && !err_data) dn_cnt++;
        if ((lock_ok != !err_oe) || (!err_oe && err_data)) bad_cnt++;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(lock_ok == 1'b1, "R1", "lock after reset", lock_ok, 1);
        check(err_oe == 1'b0, "R1", "oe after reset", err_oe, 0);
        check(err_data == 1'b0, "R1", "data after reset", err_data, 0);

        // Table of periodic patterns
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            up_cnt = 0; dn_cnt = 0; bad_cnt = 0;
            for (int i = 1; i <= STIM + TAIL; i++) begin
                ref_in = wave(i, VECS[v].rp, VECS[v].rh, VECS[v].ro);
                fb_in  = wave(i, VECS[v].fp, VECS[v].fh, VECS[v].fo);
                @(negedge clk);
                sample_out();
            end
            check(up_cnt == VECS[v].up, $sformatf("R%0d", VECS[v].req),
                  $sformatf("vector %0d high-drive samples", v), up_cnt, VECS[v].up);
            check(dn_cnt == VECS[v].dn, $sformatf("R%0d", VECS[v].req),
                  $sformatf("vector %0d low-drive samples", v), dn_cnt, VECS[v].dn);
            check(bad_cnt == 0, "R6",
                  $sformatf("vector %0d lock/enable mismatches", v), bad_cnt, 0);
        end

        // R8: repeated reference edge during high drive; one fb edge releases
        do_reset();
        up_cnt = 0; dn_cnt = 0; bad_cnt = 0;
        for (int i = 1; i <= 30; i++) begin
            ref_in = (i == 3) || (i == 9);
            fb_in  = (i == 13);
            @(negedge clk);
            sample_out();
        end
        check(up_cnt == 10, "R8", "high-drive samples with extra lead edge", up_cnt, 10);
        check(dn_cnt == 0, "R8", "low-drive samples with extra lead edge", dn_cnt, 0);
        check(lock_ok == 1'b1, "R8", "released after one fb edge", lock_ok, 1);

        // R10 latency, then R1 reset in the middle of a low drive
        do_reset();
        for (int i = 1; i <= 9; i++) begin
            fb_in = (i >= 3 && i <= 5);
            ref_in = 1'b0;
            @(negedge clk);
            if (i == 4) check(err_oe == 1'b0, "R10", "oe one edge after capture", err_oe, 0);
            if (i == 5) check(err_oe && !err_data, "R10", "low drive two edges after capture",
                              {err_oe, err_data}, 2);
        end
        check(err_oe && !err_data, "R7", "still driving low", {err_oe, err_data}, 2);
        rst = 1'b1;
        @(negedge clk);
        check(!err_oe && lock_ok, "R1", "reset during drive", {err_oe, lock_ok}, 1);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule